// File: doc/BRIEF.md
# Banked Data Memory Address Unit

This block sits between the instruction decoder of a small processor core and its 4 KB data RAM. The RAM is seen as sixteen banks of 256 bytes, so addresses are 12 bits wide (000h to FFFh). The block holds a bank register, forms the 12-bit address in one of three ways, and then performs a single byte read or write. Read data appears one clock after the request.

The decoder supplies three things: an 8-bit file offset, a select bit that chooses between the bank register and the fast-access window, and a full-address flag for register-to-register moves. In full-address mode the instruction carries the whole 12-bit address. The fast-access window joins two halves into one contiguous 256-byte region: the lower half of bank 0 and the upper half of bank 15. The upper half of bank 15 holds the special function registers, so the core reaches them without changing banks.

A parameter sets how many banks are built, counted from bank 0. Bank 15 is always built. Every other bank is unimplemented: reads from it return zero and writes to it are lost.

Top module: `bankmem_addr_unit`

## Requirements
- R1: After a synchronous reset, bank_q reads 00h and rd_vld is 0.
- R2: On a cycle with bank_ld high, the bank register takes bank_imm[3:0]. bank_q[7:4] always reads 0, whatever was loaded.
- R3: With req_full=0 and req_bnk=0 (window mode), an offset of 00h to 7Fh addresses bytes 000h to 07Fh of bank 0, whatever the bank register holds.
- R4: In window mode, an offset of 80h to FFh addresses bytes F80h to FFFh, so window offset 80h follows offset 7Fh.
- R5: With req_full=0 and req_bnk=1, the address is {bank register[3:0], req_off}.
- R6: With req_full=1, the address is req_abs[11:0]. This holds whatever req_bnk and the bank register are set to.
- R7: A read from a bank numbered IMPL_BANKS to 14 returns 00h.
- R8: A write to a bank numbered IMPL_BANKS to 14 changes no stored byte.
- R9: A read request (req_vld=1, req_we=0) raises rd_vld, with valid rd_data, exactly one cycle later. A write request does not raise rd_vld.
- R10: When bank_ld and a banked request fall in the same cycle, the address uses the bank value held before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_ld | input | 1 | Strobe that loads the bank register |
| bank_imm | input | 8 | Immediate value for the bank register |
| bank_q | output | 8 | Bank register readback, with the upper nibble always zero |
| req_vld | input | 1 | Memory request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | 1 = take the address whole from req_abs |
| req_bnk | input | 1 | 1 = use the bank register, 0 = use the split window |
| req_off | input | 8 | File offset from the instruction |
| req_abs | input | 12 | Full 12-bit address for full-address mode |
| req_wdata | input | 8 | Write data |
| rd_vld | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 8 | Read data |

## Verification
Two cases are hard to reach from the ports. The first is a lost write to an unimplemented bank, which leaves nothing behind to observe. The bench fills the whole 4 KB space with an address-dependent pattern through full-address writes, floods one unimplemented bank through banked writes, and then re-reads all 4096 addresses against a shadow model that only takes writes to built banks. The second is a bank load and a banked write in the same cycle. The bench creates it by asserting both strobes on one edge, then reads back both the old-bank and the new-bank locations.

// File: rtl/bankmem_pkg.sv
package bankmem_pkg;
  localparam int ADDR_W = 12;
  localparam int OFF_W  = 8;
  localparam int BANK_W = ADDR_W - OFF_W;
  localparam int DATA_W = 8;
  localparam logic [BANK_W-1:0] TOP_BANK = '1;

  typedef enum logic [1:0] {
    MODE_WINDOW = 2'd0,
    MODE_BANKED = 2'd1,
    MODE_FULL   = 2'd2
  } amode_e;
endpackage

// File: rtl/bankmem_bank_reg.sv
module bankmem_bank_reg
  import bankmem_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [REG_W-1:0] imm,
  output logic [REG_W-1:0] q
);
  localparam int PAD_W = REG_W - BANK_W;

  logic [BANK_W-1:0] bank_r;

  always_ff @(posedge clk) begin
    if (rst)      bank_r <= '0;
    else if (ld)  bank_r <= imm[BANK_W-1:0];
  end

  assign q = {{PAD_W{1'b0}}, bank_r};

  p_bank_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld |=> (q == {{PAD_W{1'b0}}, $past(imm[BANK_W-1:0])}));
endmodule

// File: rtl/bankmem_addr_former.sv
module bankmem_addr_former
  import bankmem_pkg::*;
(
  input  amode_e             mode,
  input  logic [BANK_W-1:0]  bank,
  input  logic [OFF_W-1:0]   off,
  input  logic [ADDR_W-1:0]  abs_addr,
  output logic [ADDR_W-1:0]  addr
);
  always_comb begin
    unique case (mode)
      MODE_WINDOW: addr = off[OFF_W-1] ? {TOP_BANK, off} : {{BANK_W{1'b0}}, off};
      MODE_BANKED: addr = {bank, off};
      MODE_FULL:   addr = abs_addr;
      default:     addr = abs_addr;
    endcase
  end
endmodule

// File: rtl/bankmem_ram.sv
module bankmem_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/bankmem_addr_unit.sv
module bankmem_addr_unit
  import bankmem_pkg::*;
#(
  parameter int IMPL_BANKS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bank_ld,
  input  logic [7:0]  bank_imm,
  output logic [7:0]  bank_q,
  input  logic        req_vld,
  input  logic        req_we,
  input  logic        req_full,
  input  logic        req_bnk,
  input  logic [7:0]  req_off,
  input  logic [11:0] req_abs,
  input  logic [7:0]  req_wdata,
  output logic        rd_vld,
  output logic [7:0]  rd_data
);
  localparam int MAIN_DEPTH = IMPL_BANKS * (1 << OFF_W);
  localparam int MAIN_AW    = $clog2(MAIN_DEPTH);
  localparam logic [BANK_W-1:0] IMPL_LIM = BANK_W'(IMPL_BANKS);

  amode_e              mode;
  logic [ADDR_W-1:0]   addr;
  logic [BANK_W-1:0]   abank;
  logic                hit_main, hit_top;
  logic                main_en, main_we, top_en, top_we;
  logic [DATA_W-1:0]   q_main, q_top;
  logic                rd_vld_q, sel_main_q, sel_top_q;

  bankmem_bank_reg #(.REG_W(8)) u_bank (
    .clk(clk), .rst(rst), .ld(bank_ld), .imm(bank_imm), .q(bank_q)
  );

  assign mode = req_full ? MODE_FULL : (req_bnk ? MODE_BANKED : MODE_WINDOW);

  bankmem_addr_former u_addr (
    .mode(mode), .bank(bank_q[BANK_W-1:0]), .off(req_off),
    .abs_addr(req_abs), .addr(addr)
  );

  assign abank    = addr[ADDR_W-1:OFF_W];
  assign hit_main = (abank < IMPL_LIM);
  assign hit_top  = (abank == TOP_BANK);
  assign main_en  = req_vld & hit_main;
  assign main_we  = main_en & req_we;
  assign top_en   = req_vld & hit_top;
  assign top_we   = top_en & req_we;

  bankmem_ram #(.DEPTH(MAIN_DEPTH), .DW(DATA_W)) u_ram_main (
    .clk(clk), .en(main_en), .we(main_we), .addr(addr[MAIN_AW-1:0]),
    .wdata(req_wdata), .q(q_main)
  );

  bankmem_ram #(.DEPTH(1 << OFF_W), .DW(DATA_W)) u_ram_top (
    .clk(clk), .en(top_en), .we(top_we), .addr(addr[OFF_W-1:0]),
    .wdata(req_wdata), .q(q_top)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_q   <= 1'b0;
      sel_main_q <= 1'b0;
      sel_top_q  <= 1'b0;
    end else begin
      rd_vld_q   <= req_vld & ~req_we;
      sel_main_q <= req_vld & ~req_we & hit_main;
      sel_top_q  <= req_vld & ~req_we & hit_top;
    end
  end

  assign rd_vld  = rd_vld_q;
  assign rd_data = sel_main_q ? q_main : (sel_top_q ? q_top : '0);

  p_window_low_r3: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !req_full && !req_bnk && !req_off[7]) |-> (addr == {4'h0, req_off}));
  p_window_high_r4: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !req_full && !req_bnk && req_off[7]) |-> (addr == {4'hF, req_off}));
  p_banked_r5: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !req_full && req_bnk) |-> (addr == {bank_q[3:0], req_off}));
  p_full_r6: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_full) |-> (addr == req_abs));
  p_unimpl_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !req_we && !hit_main && !hit_top) |=> (rd_vld && rd_data == 8'h00));
  p_unimpl_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_we && abank >= IMPL_LIM && abank != 4'hF) |-> (!main_we && !top_we));
  p_read_latency_r9: assert property (@(posedge clk) disable iff (rst)
    (req_vld && !req_we) |=> rd_vld);
  p_write_no_vld_r9: assert property (@(posedge clk) disable iff (rst)
    !(req_vld && !req_we) |=> !rd_vld);
  p_old_bank_r10: assert property (@(posedge clk) disable iff (rst)
    (bank_ld && req_vld && !req_full && req_bnk) |-> (addr[11:8] == bank_q[3:0]));
endmodule

// File: tb/bankmem_addr_unit_tb.sv
module bankmem_addr_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IMPL = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        bank_ld;
  logic [7:0]  bank_imm;
  logic [7:0]  bank_q;
  logic        req_vld, req_we, req_full, req_bnk;
  logic [7:0]  req_off;
  logic [11:0] req_abs;
  logic [7:0]  req_wdata;
  logic        rd_vld;
  logic [7:0]  rd_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] shadow [4096];

  always #(CLK_PERIOD/2) clk = ~clk;

  bankmem_addr_unit #(.IMPL_BANKS(IMPL)) u_dut (
    .clk(clk), .rst(rst), .bank_ld(bank_ld), .bank_imm(bank_imm), .bank_q(bank_q),
    .req_vld(req_vld), .req_we(req_we), .req_full(req_full), .req_bnk(req_bnk),
    .req_off(req_off), .req_abs(req_abs), .req_wdata(req_wdata),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );

  function automatic bit built(input logic [11:0] a);
    return (int'(a[11:8]) < IMPL) || (a[11:8] == 4'hF);
  endfunction

  function automatic logic [7:0] pat(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  function automatic logic [11:0] win_addr(input logic [7:0] off);
    return off[7] ? {4'hF, off} : {4'h0, off};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_vld = 0; req_we = 0; bank_ld = 0;
  endtask

  task automatic load_bank(input logic [7:0] v);
    @(negedge clk); bank_ld = 1; bank_imm = v;
    @(negedge clk); bank_ld = 0;
  endtask

  task automatic wr(input logic full, input logic bnk, input logic [7:0] off,
                    input logic [11:0] abs_a, input logic [7:0] d, input logic [11:0] eff);
    @(negedge clk);
    req_vld = 1; req_we = 1; req_full = full; req_bnk = bnk;
    req_off = off; req_abs = abs_a; req_wdata = d;
    @(negedge clk); idle();
    if (built(eff)) shadow[eff] = d;
  endtask

  task automatic rd(input string req, input logic full, input logic bnk,
                    input logic [7:0] off, input logic [11:0] abs_a, input logic [11:0] eff);
    @(negedge clk);
    req_vld = 1; req_we = 0; req_full = full; req_bnk = bnk;
    req_off = off; req_abs = abs_a;
    @(negedge clk); idle();
    chk("R9 rd_vld", {7'd0, rd_vld}, 8'd1);
    chk(req, rd_data, built(eff) ? shadow[eff] : 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) shadow[i] = 8'h00;
    rst = 1; idle(); req_full = 0; req_bnk = 0; req_off = 0; req_abs = 0;
    req_wdata = 0; bank_imm = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 bank_q", bank_q, 8'h00);
    chk("R1 rd_vld", {7'd0, rd_vld}, 8'd0);

    // R2: upper nibble never stored
    load_bank(8'hF3);
    chk("R2", bank_q, 8'h03);
    load_bank(8'hA0);
    chk("R2", bank_q, 8'h00);

    // R6/R8: fill whole space in full mode, bank register ignored
    load_bank(8'h09);
    for (int a = 0; a < 4096; a++)
      wr(1'b1, a[0], a[7:0] ^ 8'hFF, 12'(a), pat(12'(a)), 12'(a));
    for (int a = 0; a < 4096; a++)
      rd(built(12'(a)) ? "R6" : "R7", 1'b1, ~a[0], 8'h00, 12'(a), 12'(a));

    // R5: banked reads across every bank
    for (int b = 0; b < 16; b++) begin
      load_bank(8'(b));
      for (int o = 0; o < 256; o++)
        rd(built({4'(b), 8'(o)}) ? "R5" : "R7", 1'b0, 1'b1, 8'(o), 12'h000, {4'(b), 8'(o)});
    end

    // R3/R4: window reads with an unbuilt bank selected
    load_bank(8'h05);
    for (int o = 0; o < 256; o++)
      rd(o < 128 ? "R3" : "R4", 1'b0, 1'b0, 8'(o), 12'hABC, win_addr(8'(o)));
    wr(1'b0, 1'b0, 8'h7F, 12'h000, 8'hC3, 12'h07F);
    wr(1'b0, 1'b0, 8'h80, 12'h000, 8'h3C, 12'hF80);
    rd("R3", 1'b1, 1'b0, 8'h00, 12'h07F, 12'h07F);
    rd("R4", 1'b1, 1'b0, 8'h00, 12'hF80, 12'hF80);
    chk("R3 value", shadow[12'h07F], 8'hC3);
    chk("R4 value", shadow[12'hF80], 8'h3C);

    // R8: flood an unbuilt bank, then check the whole space is unchanged
    load_bank(8'h07);
    for (int o = 0; o < 256; o++)
      wr(1'b0, 1'b1, 8'(o), 12'h000, 8'hFF, {4'h7, 8'(o)});
    for (int a = 0; a < 4096; a++)
      rd(built(12'(a)) ? "R8" : "R7", 1'b1, 1'b0, 8'h00, 12'(a), 12'(a));

    // R10: load and banked write in the same cycle use the old bank
    load_bank(8'h01);
    @(negedge clk);
    bank_ld = 1; bank_imm = 8'h00;
    req_vld = 1; req_we = 1; req_full = 0; req_bnk = 1; req_off = 8'h10; req_wdata = 8'hA5;
    @(negedge clk); idle();
    shadow[12'h110] = 8'hA5;
    chk("R10 bank_q", bank_q, 8'h00);
    rd("R10 old bank", 1'b1, 1'b0, 8'h00, 12'h110, 12'h110);
    rd("R10 new bank", 1'b1, 1'b0, 8'h00, 12'h010, 12'h010);
    chk("R10 untouched", shadow[12'h010], pat(12'h010));

    // R9: a write gives no rd_vld
    @(negedge clk);
    req_vld = 1; req_we = 1; req_full = 1; req_abs = 12'hF00; req_wdata = 8'h11;
    @(negedge clk); idle(); shadow[12'hF00] = 8'h11;
    chk("R9 write", {7'd0, rd_vld}, 8'd0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule